// File: doc/BRIEF.md
# Virtually indexed, physically tagged direct-mapped cache lookup

This block is the lookup path of a direct-mapped data cache that sits beside a translation lookaside buffer. Every address bit that selects a line or a word lies inside the page offset, which translation never changes. The line can therefore be read from the arrays on the same clock edge that starts the translation. One cycle later the buffer delivers the physical page number and its hit flag. The block compares that page number with the stored physical tag and returns hit or miss together with the selected 32-bit word.

Lines come in through a fill port. It writes a whole line, its physical tag and its valid bit at the index taken from the fill's virtual address. A single invalidate pulse empties the cache. At the default geometry the untranslated bits cover the whole index: 16 KB of storage, 64-byte lines, 256 lines and 16 KB pages. Other parameter sets can make the index reach into the virtual page number. The block reports that case on a constant output, and a second output flags any access whose virtual and physical page numbers disagree in those bits.

Top module: `vipt_cache`

## Requirements
- R1: After synchronous reset every line is invalid. With no lookup pending, `rsp_valid`, `rsp_hit` and `rsp_miss` are low, and the first lookup after reset misses.
- R2: The line index is virtual address bits [13:6] and the word is bits [5:2]. Bits [1:0] and the virtual page number bits [31:14] have no effect on which line or word is read.
- R3: A lookup presented with `lk_req` high at a clock edge produces `rsp_valid` high during the following cycle only. `tlb_ppn` and `tlb_hit` are taken during that following cycle, and the result reaches the outputs combinationally.
- R4: `rsp_hit` is high only when the line is valid, `tlb_hit` is high and the stored tag equals `tlb_ppn`.
- R5: When `tlb_hit` is low the response is a miss, whatever the cache holds.
- R6: A fill writes `fill_line`, the tag `fill_ppn` and a set valid bit at index `fill_va[13:6]`.
- R7: On a hit `rsp_data` is `line[32*w+31 : 32*w]`, where w = va[5:2]. On a miss `rsp_data` is zero.
- R8: `inval_all` clears every valid bit. A fill at the same edge still leaves its own line valid.
- R9: A lookup and a fill to the same index at the same edge return the contents from before the fill. Later lookups see the new line.
- R10: At the default geometry `cfg_vpn_index` is 0 and `place_err` stays low for any address pair.
- R11: While `rsp_valid` is high, exactly one of `rsp_hit` and `rsp_miss` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Start a lookup this edge |
| lk_va | input | 32 | Virtual address of the lookup |
| tlb_ppn | input | 18 | Translated page number, response cycle |
| tlb_hit | input | 1 | Translation valid, response cycle |
| fill_en | input | 1 | Write a line this edge |
| fill_va | input | 32 | Virtual address choosing the fill index |
| fill_ppn | input | 18 | Physical tag stored with the fill |
| fill_line | input | 512 | Line data, word w at bits 32w+31..32w |
| inval_all | input | 1 | Clear all valid bits |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_data | output | 32 | Selected word, zero on miss |
| place_err | output | 1 | Index bits from the page number disagree with the translation |
| cfg_vpn_index | output | 1 | Geometry needs page-number bits for the index |

## Verification
The hardest case to reach from the ports is a lookup that meets a fill to the same line on the same edge. The array read must return the old line and old tag while the new ones are being written, and the translation arriving a cycle later has to be matched against the old tag. The bench builds this case on purpose: it fills a line, then issues a lookup and a refill of that index together, presenting the old page number. The random phase keeps lookups on a small pool of indices so that hits, tag mismatches and translation misses all occur often.

// File: rtl/vipt_pkg.sv
// Package: default geometry of the lookup and a helper for the placement rule.
// Assumes power-of-two line count and line size.
package vipt_pkg;
    localparam int unsigned DEF_VA_W       = 32;
    localparam int unsigned DEF_PPN_W      = 18;
    localparam int unsigned DEF_PAGE_OFF_W = 14;
    localparam int unsigned DEF_LINE_BYTES = 64;
    localparam int unsigned DEF_LINES      = 256;
    localparam int unsigned DEF_WORD_BYTES = 4;

    // Number of index bits that fall above the page offset (0 when none do).
    function automatic int unsigned vpn_index_bits(int unsigned span_w, int unsigned page_w);
        return (span_w > page_w) ? span_w - page_w : 0;
    endfunction
endpackage

// File: rtl/vipt_place_check.sv
// Placement check: compares the page-number bits used by the index with the
// low bits of the physical page number. Assumes the page number is at least
// as wide as the number of such bits.
module vipt_place_check
    import vipt_pkg::*;
#(
    parameter int unsigned VA_W       = DEF_VA_W,
    parameter int unsigned PPN_W      = DEF_PPN_W,
    parameter int unsigned PAGE_OFF_W = DEF_PAGE_OFF_W,
    parameter int unsigned SPAN_W     = 14
) (
    input  logic [VA_W-1:0]  va,
    input  logic [PPN_W-1:0] ppn,
    output logic             mismatch
);
    localparam int unsigned EXTRA = vpn_index_bits(SPAN_W, PAGE_OFF_W);

    logic unused_bits;
    assign unused_bits = ^{va, ppn};

    generate
        if (EXTRA > 0) begin : g_vpn_idx
            // Mismatch when the translated bits differ from the virtual ones.
            assign mismatch = (va[PAGE_OFF_W +: EXTRA] != ppn[EXTRA-1:0]);
        end else begin : g_offset_idx
            // The index lies inside the offset, so aliasing cannot occur.
            assign mismatch = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/vipt_tag_store.sv
// Tag store: a valid bit and a physical tag per line. The read is registered,
// so the tag appears in the cycle after the request. Writes and invalidates
// take effect at the edge. A read at the same edge sees the old state.
module vipt_tag_store #(
    parameter int unsigned LINES = 256,
    parameter int unsigned TAG_W = 18,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             inval_all,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid bits: reset and invalidate clear all, a fill then sets its line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (inval_all) valid_q <= '0;
            if (wr_en)     valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag array: written on fill, not reset.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    // Registered read of valid bit and tag for the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else if (rd_en) begin
            rd_valid <= valid_q[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_tag <= tag_q[rd_idx];
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> valid_q == '0); // R1
    AST_INVAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all && !wr_en |=> valid_q == '0); // R8
    AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]); // R6
endmodule

// File: rtl/vipt_data_store.sv
// Data store: one full line per index, registered whole-line read and word
// selection in the response cycle. Assumes the line holds a power-of-two
// number of words.
module vipt_data_store #(
    parameter int unsigned LINES  = 256,
    parameter int unsigned LINE_W = 512,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W  = $clog2(LINES),
    localparam int unsigned WORDS  = LINE_W / WORD_W,
    localparam int unsigned WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [WSEL_W-1:0] word_sel,
    output logic [WORD_W-1:0] rd_word
);
    logic [LINE_W-1:0] line_q [LINES];
    logic [LINE_W-1:0] rd_line_q;
    logic [WORD_W-1:0] words [WORDS];

    // Line array write on fill.
    always_ff @(posedge clk) begin
        if (wr_en) line_q[wr_idx] <= wr_line;
    end

    // Registered whole-line read for the lookup.
    always_ff @(posedge clk) begin
        if (rd_en) rd_line_q <= line_q[rd_idx];
    end

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            // Slice word w out of the read line.
            assign words[w] = rd_line_q[w*WORD_W +: WORD_W];
        end
    endgenerate

    // Word multiplexer driven by the registered byte-offset bits.
    assign rd_word = words[word_sel];

    AST_FILL_LINE: assert property (@(posedge clk)
        wr_en |=> line_q[$past(wr_idx)] == $past(wr_line)); // R6
endmodule

// File: rtl/vipt_cache.sv
// Top: virtually indexed, physically tagged direct-mapped lookup. The arrays
// are read at the request edge from untranslated bits. The translation that
// arrives in the next cycle is compared with the stored tag. Assumes the
// companion translation buffer answers exactly one cycle after the request.
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int unsigned VA_W       = DEF_VA_W,
    parameter int unsigned PPN_W      = DEF_PPN_W,
    parameter int unsigned PAGE_OFF_W = DEF_PAGE_OFF_W,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned LINES      = DEF_LINES,
    parameter int unsigned WORD_BYTES = DEF_WORD_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_req,
    input  logic [VA_W-1:0]         lk_va,
    input  logic [PPN_W-1:0]        tlb_ppn,
    input  logic                    tlb_hit,
    input  logic                    fill_en,
    input  logic [VA_W-1:0]         fill_va,
    input  logic [PPN_W-1:0]        fill_ppn,
    input  logic [LINE_BYTES*8-1:0] fill_line,
    input  logic                    inval_all,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_miss,
    output logic [WORD_BYTES*8-1:0] rsp_data,
    output logic                    place_err,
    output logic                    cfg_vpn_index
);
    localparam int unsigned OFS_W  = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W  = $clog2(LINES);
    localparam int unsigned BSEL_W = $clog2(WORD_BYTES);
    localparam int unsigned WSEL_W = OFS_W - BSEL_W;
    localparam int unsigned LINE_W = LINE_BYTES * 8;
    localparam int unsigned WORD_W = WORD_BYTES * 8;
    localparam int unsigned SPAN_W = IDX_W + OFS_W;

    logic             rsp_valid_q;
    logic [VA_W-1:0]  va_q;
    logic             line_valid;
    logic [PPN_W-1:0] line_tag;
    logic [WORD_W-1:0] line_word;
    logic             tag_match;
    logic             hit_now;
    logic             lk_mis;
    logic             fill_mis;

    // Response-cycle marker and the registered lookup address.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid_q <= 1'b0;
        else        rsp_valid_q <= lk_req;
    end

    always_ff @(posedge clk) begin
        if (lk_req) va_q <= lk_va;
    end

    vipt_tag_store #(.LINES(LINES), .TAG_W(PPN_W)) i_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (lk_req),
        .rd_idx    (lk_va[OFS_W +: IDX_W]),
        .wr_en     (fill_en),
        .wr_idx    (fill_va[OFS_W +: IDX_W]),
        .wr_tag    (fill_ppn),
        .inval_all (inval_all),
        .rd_valid  (line_valid),
        .rd_tag    (line_tag)
    );

    vipt_data_store #(.LINES(LINES), .LINE_W(LINE_W), .WORD_W(WORD_W)) i_data (
        .clk      (clk),
        .rd_en    (lk_req),
        .rd_idx   (lk_va[OFS_W +: IDX_W]),
        .wr_en    (fill_en),
        .wr_idx   (fill_va[OFS_W +: IDX_W]),
        .wr_line  (fill_line),
        .word_sel (va_q[BSEL_W +: WSEL_W]),
        .rd_word  (line_word)
    );

    vipt_place_check #(.VA_W(VA_W), .PPN_W(PPN_W), .PAGE_OFF_W(PAGE_OFF_W),
                       .SPAN_W(SPAN_W)) i_lk_place (
        .va       (va_q),
        .ppn      (tlb_ppn),
        .mismatch (lk_mis)
    );

    vipt_place_check #(.VA_W(VA_W), .PPN_W(PPN_W), .PAGE_OFF_W(PAGE_OFF_W),
                       .SPAN_W(SPAN_W)) i_fill_place (
        .va       (fill_va),
        .ppn      (fill_ppn),
        .mismatch (fill_mis)
    );

    // Physical tag compare against the late-arriving translation.
    always_comb begin
        tag_match = (line_tag == tlb_ppn);
        hit_now   = rsp_valid_q && line_valid && tlb_hit && tag_match;
    end

    assign rsp_valid     = rsp_valid_q;
    assign rsp_hit       = hit_now;
    assign rsp_miss      = rsp_valid_q && !hit_now;
    assign rsp_data      = hit_now ? line_word : '0;
    assign place_err     = (rsp_valid_q && tlb_hit && lk_mis) || (fill_en && fill_mis);
    assign cfg_vpn_index = (SPAN_W > PAGE_OFF_W);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_req)); // R3
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit && !rsp_miss); // R1
endmodule

// File: tb/test_vipt_cache.sv
module test_vipt_cache;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         lk_req;
    logic [31:0]  lk_va;
    logic [17:0]  tlb_ppn;
    logic         tlb_hit;
    logic         fill_en;
    logic [31:0]  fill_va;
    logic [17:0]  fill_ppn;
    logic [511:0] fill_line;
    logic         inval_all;
    logic         rsp_valid, rsp_hit, rsp_miss, place_err, cfg_vpn_index;
    logic [31:0]  rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit           m_valid [256];
    logic [17:0]  m_tag   [256];
    logic [511:0] m_line  [256];

    always #5 clk = ~clk;

    vipt_cache i_vipt_cache (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
        .tlb_ppn(tlb_ppn), .tlb_hit(tlb_hit), .fill_en(fill_en),
        .fill_va(fill_va), .fill_ppn(fill_ppn), .fill_line(fill_line),
        .inval_all(inval_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_data(rsp_data), .place_err(place_err),
        .cfg_vpn_index(cfg_vpn_index)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(logic [31:0] va, logic [17:0] ppn, bit th);
        return th && m_valid[va[13:6]] && (m_tag[va[13:6]] == ppn);
    endfunction

    function automatic logic [31:0] exp_data(logic [31:0] va, logic [17:0] ppn, bit th);
        logic [511:0] l;
        if (!exp_hit(va, ppn, th)) return 32'h0;
        l = m_line[va[13:6]];
        return l[va[5:2]*32 +: 32];
    endfunction

    function automatic logic [511:0] rand_line();
        logic [511:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = $urandom;
        return l;
    endfunction

    // Response bundle: {valid, hit, miss, place_err, data}
    function automatic logic [63:0] bundle(bit v, bit h, bit m, bit p, logic [31:0] d);
        return {28'h0, v, h, m, p, d};
    endfunction

    // Lookup: request edge, then translation in the response cycle.
    task automatic lookup(logic [31:0] va, logic [17:0] ppn, bit th, string req);
        bit eh;
        logic [31:0] ed;
        eh = exp_hit(va, ppn, th);
        ed = exp_data(va, ppn, th);
        lk_req = 1'b1; lk_va = va;
        @(posedge clk); @(negedge clk);
        lk_req = 1'b0; tlb_ppn = ppn; tlb_hit = th;
        #1;
        chk(req, bundle(rsp_valid, rsp_hit, rsp_miss, place_err, rsp_data),
            bundle(1'b1, eh, !eh, 1'b0, ed));
    endtask

    task automatic fill(logic [31:0] va, logic [17:0] ppn, logic [511:0] l);
        fill_en = 1'b1; fill_va = va; fill_ppn = ppn; fill_line = l;
        @(posedge clk); @(negedge clk);
        fill_en = 1'b0; #1;
        m_valid[va[13:6]] = 1'b1; m_tag[va[13:6]] = ppn; m_line[va[13:6]] = l;
    endtask

    task automatic inval(bit with_fill, logic [31:0] va, logic [17:0] ppn, logic [511:0] l);
        inval_all = 1'b1;
        fill_en = with_fill; fill_va = va; fill_ppn = ppn; fill_line = l;
        @(posedge clk); @(negedge clk);
        inval_all = 1'b0; fill_en = 1'b0; #1;
        for (int i = 0; i < 256; i++) m_valid[i] = 1'b0;
        if (with_fill) begin
            m_valid[va[13:6]] = 1'b1; m_tag[va[13:6]] = ppn; m_line[va[13:6]] = l;
        end
    endtask

    task automatic idle_check(string req);
        @(posedge clk); @(negedge clk); #1;
        chk(req, bundle(rsp_valid, rsp_hit, rsp_miss, 1'b0, 32'h0),
            bundle(1'b0, 1'b0, 1'b0, 1'b0, 32'h0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [511:0] la, lb;
        logic [31:0] va;
        logic [17:0] pp;
        int unsigned seed_junk;
        seed_junk = $urandom(32'd4242);
        for (int i = 0; i < 256; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_line[i] = '0; end
        rst_n = 0; lk_req = 0; lk_va = 0; tlb_ppn = 0; tlb_hit = 0;
        fill_en = 0; fill_va = 0; fill_ppn = 0; fill_line = 0; inval_all = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;

        // R1: quiet after reset, first lookup misses
        chk("R1 idle", bundle(rsp_valid, rsp_hit, rsp_miss, 1'b0, 32'h0), 64'h0);
        lookup(32'h0000_0140, 18'h0, 1'b1, "R1 first lookup");
        // R10: configuration flag at defaults
        chk("R10 cfg", {63'h0, cfg_vpn_index}, 64'h0);

        // R6/R7: fill then read several words
        la = rand_line();
        fill(32'h1234_5140, 18'h2A5A5, la);
        lookup(32'h1234_5140, 18'h2A5A5, 1'b1, "R6 fill hit word0");
        lookup(32'h1234_517C, 18'h2A5A5, 1'b1, "R7 word15");
        lookup(32'h1234_5158, 18'h2A5A5, 1'b1, "R7 word6");
        // R2: byte bits and page number bits do not change the selection
        lookup(32'h1234_515B, 18'h2A5A5, 1'b1, "R2 byte bits");
        lookup(32'hFEDC_5158, 18'h2A5A5, 1'b1, "R2 vpn bits");
        // R4: tag mismatch
        lookup(32'h1234_5140, 18'h2A5A4, 1'b1, "R4 tag mismatch");
        // R5: translation miss forces miss
        lookup(32'h1234_5140, 18'h2A5A5, 1'b0, "R5 tlb miss");
        // R3: single response cycle
        lookup(32'h1234_5140, 18'h2A5A5, 1'b1, "R3 response");
        idle_check("R3 no second response");

        // R9: lookup and refill of the same index at one edge
        lb = rand_line();
        va = 32'h0000_5144;
        begin
            bit eh; logic [31:0] ed;
            eh = exp_hit(va, 18'h2A5A5, 1'b1);
            ed = exp_data(va, 18'h2A5A5, 1'b1);
            lk_req = 1; lk_va = va;
            fill_en = 1; fill_va = 32'h0000_5140; fill_ppn = 18'h01111; fill_line = lb;
            @(posedge clk); @(negedge clk);
            lk_req = 0; fill_en = 0; tlb_ppn = 18'h2A5A5; tlb_hit = 1; #1;
            chk("R9 old contents", bundle(rsp_valid, rsp_hit, rsp_miss, place_err, rsp_data),
                bundle(1'b1, eh, !eh, 1'b0, ed));
            m_tag[8'h45] = 18'h01111; m_line[8'h45] = lb; m_valid[8'h45] = 1;
        end
        lookup(32'h0000_5144, 18'h01111, 1'b1, "R9 new contents");

        // R8: invalidate, then invalidate with concurrent fill
        fill(32'h0000_0A00, 18'h00033, rand_line());
        inval(1'b0, 32'h0, 18'h0, '0);
        lookup(32'h0000_5144, 18'h01111, 1'b1, "R8 cleared");
        lookup(32'h0000_0A00, 18'h00033, 1'b1, "R8 cleared other");
        la = rand_line();
        inval(1'b1, 32'h0000_0A08, 18'h00077, la);
        lookup(32'h0000_0A08, 18'h00077, 1'b1, "R8 fill survives");
        lookup(32'h0000_5144, 18'h01111, 1'b1, "R8 others invalid");

        // Random phase on a small index pool
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [7:0] idx;
            op = $urandom % 10;
            idx = 8'((($urandom % 8) * 37) & 8'hFF);
            va = {$urandom % 32'h40000, 14'h0} | {18'h0, idx, 6'h0} | ($urandom % 64);
            if (op < 3) begin
                fill(va, 18'($urandom), rand_line());
            end else if (op == 3 && ($urandom % 8) == 0) begin
                inval(($urandom % 2) == 1, va, 18'($urandom), rand_line());
            end else begin
                pp = (($urandom % 10) < 7) ? m_tag[idx] : 18'($urandom);
                lookup(va, pp, ($urandom % 8) != 0, "R4 random");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule